// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block follows a debug session through up to three intermediate steps and raises a trigger once a programmed chain of comparator events has occurred. Four single-cycle match pulses, one per comparator channel, come in from outside. While the sequencer is armed, it sits in Step1, Step2 or Step3. Each step has its own 4-bit selection code, and that code decides which channels move the sequencer and where they move it. When the sequencer reaches the Final state it pulses a trigger for one cycle and then stays disarmed until it is armed again.

Alongside the state machine, the block keeps a four-bit sticky record of every channel that matched during the armed session. Only hardware sets these flags, and only a new arm clears them, so software can still inspect them after the session is over.

A small register port carries the control word (bank select and an arm bit) and a shared data window at offset 0x27. Through that window the three selection codes can be read and written, and the flags can be read.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, state_o is Idle (0), trig_o is 0, flags_o is 0, the bank select is 0 and all three selection codes are 0.
- R2: An arm happens when arm_i is 1 or a control write (offset 0x26) has data bit 7 set. On the next cycle state_o is Step1 (1) and flags_o is 0. An arm takes precedence over any match in the same cycle.
- R3: While state_o is Step1, Step2 or Step3 (1..3), a match on channel i sets flags_o[i]. A flag that is already set stays set, and other flags are unaffected.
- R4: Flags are never cleared except by an arm. Writes to the window while the bank select is 3 change nothing. The flags keep their values after the Final state is reached.
- R5: While state_o is Idle (0) or Final (4), matches change neither state_o nor flags_o.
- R6: The code of the current step gives these transitions (F = Final, Sn = Step n). 1: any match to F. 2..5: match(code-2) to F. 6: M0 to S1. 7: M1 to S2. 8: M2 to S3. 9: M3 to S2. A: M0 to F, M1 to S2. B: M1 to F, M2 to S3. C: M2 to F, M3 to S1. D: M3 to F, M0 to S2. E: M1 to S2, M3 to S3. Matches on channels the code does not name are ignored.
- R7: Codes 0 and F are reserved, and no match causes a transition under them.
- R8: When several named matches occur in the same cycle, a match leading to Final wins. Among matches that do not lead to Final, the lowest channel number wins.
- R9: On entry to Final, trig_o is 1 during the first cycle in which state_o reads 4, and 0 afterwards. Final holds until the next arm.
- R10: Offset 0x26 reads {6'b0, bank} and a write to it stores bank = data[1:0]. At offset 0x27, bank 0, 1 or 2 reads and writes the Step1, Step2 or Step3 code in bits 3:0, and bank 3 reads {4'b0, flags}. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Arm strobe |
| match_i | input | 4 | Comparator match pulses, bit i = channel i |
| reg_addr | input | 6 | Register offset |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| state_o | output | 3 | Sequencer state: 0 Idle, 1..3 Step1..Step3, 4 Final |
| trig_o | output | 1 | One-cycle pulse on entering Final |
| flags_o | output | 4 | Sticky per-channel match flags |

## Verification
The assertions check the following on every cycle: an arm always leads to Step1 with cleared flags, a flag can only rise after a match on its own channel, flags fall only after an arm, the state is frozen while disarmed, and the trigger is a single cycle tied to entry into Final. Whether the correct transition was taken can only be shown by the bench scenarios, because it depends on the selection code and on the priority among simultaneous matches. The same applies to reserved codes being inert and to the register window returning the right code or flags for each bank.

// File: rtl/dbgseq_pkg.sv
// Package: shared types and the selection-code decoder for the debug sequencer.
// Assumes four match channels and three intermediate steps.
package dbgseq_pkg;

    localparam int NUM_CH    = 4;
    localparam int NUM_STEPS = 3;
    localparam int SEL_W     = 4;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 2;
    localparam int ARM_BIT   = 7;
    localparam int STEP_IW   = $clog2(NUM_STEPS + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_S1    = 3'd1,
        ST_S2    = 3'd2,
        ST_S3    = 3'd3,
        ST_FINAL = 3'd4
    } seq_state_t;

    // Decoded rule: channels that go to Final, channels that go to a step, and the step index.
    typedef struct packed {
        logic [NUM_CH-1:0]              to_final;
        logic [NUM_CH-1:0]              to_step;
        logic [NUM_CH-1:0][STEP_IW-1:0] step_dest;
    } sel_rule_t;

    // Turns a 4-bit selection code into per-channel transition rules.
    function automatic sel_rule_t decode_sel(input logic [SEL_W-1:0] code);
        sel_rule_t r;
        r = '0;
        case (code)
            4'h1: r.to_final = '1;
            4'h2, 4'h3, 4'h4, 4'h5:
                r.to_final = NUM_CH'(1) << (code - 4'd2);
            4'h6: begin r.to_step[0] = 1'b1; r.step_dest[0] = 2'd1; end
            4'h7: begin r.to_step[1] = 1'b1; r.step_dest[1] = 2'd2; end
            4'h8: begin r.to_step[2] = 1'b1; r.step_dest[2] = 2'd3; end
            4'h9: begin r.to_step[3] = 1'b1; r.step_dest[3] = 2'd2; end
            4'hA: begin r.to_final[0] = 1'b1; r.to_step[1] = 1'b1; r.step_dest[1] = 2'd2; end
            4'hB: begin r.to_final[1] = 1'b1; r.to_step[2] = 1'b1; r.step_dest[2] = 2'd3; end
            4'hC: begin r.to_final[2] = 1'b1; r.to_step[3] = 1'b1; r.step_dest[3] = 2'd1; end
            4'hD: begin r.to_final[3] = 1'b1; r.to_step[0] = 1'b1; r.step_dest[0] = 2'd2; end
            4'hE: begin
                r.to_step[1] = 1'b1; r.step_dest[1] = 2'd2;
                r.to_step[3] = 1'b1; r.step_dest[3] = 2'd3;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbgseq_regs.sv
// Register file: holds the bank select and the three per-step selection codes,
// decodes the arm bit of a control write and drives the read mux.
// Assumes single-cycle writes and combinational reads.
module dbgseq_regs
    import dbgseq_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 6'h26,
    parameter logic [ADDR_W-1:0] WIN_OFS  = 6'h27
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic                            reg_wr,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic [NUM_CH-1:0]               flags,
    output logic [NUM_STEPS-1:0][SEL_W-1:0] sel_codes,
    output logic                            arm_wr,
    output logic [DATA_W-1:0]               reg_rdata
);

    localparam logic [BANK_W-1:0] BANK_FLAGS = BANK_W'(NUM_STEPS);

    logic [BANK_W-1:0] bank_q;
    logic              ctrl_wr;
    logic              win_wr;

    assign ctrl_wr = reg_wr && (reg_addr == CTRL_OFS);
    assign win_wr  = reg_wr && (reg_addr == WIN_OFS);
    assign arm_wr  = ctrl_wr && reg_wdata[ARM_BIT];

    // Bank select register, loaded by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (ctrl_wr) bank_q <= reg_wdata[BANK_W-1:0];
    end

    // One selection-code register per step, written through the window.
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_codes[g] <= '0;
            else if (win_wr && (bank_q == BANK_W'(g)))
                sel_codes[g] <= reg_wdata[SEL_W-1:0];
        end
    end

    // Read mux: control word, window (code or flags by bank), zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[BANK_W-1:0] = bank_q;
        end else if (reg_addr == WIN_OFS) begin
            if (bank_q == BANK_FLAGS) reg_rdata[NUM_CH-1:0] = flags;
            else                      reg_rdata[SEL_W-1:0]  = sel_codes[bank_q];
        end
    end

endmodule

// File: rtl/dbgseq_fsm.sv
// State sequencer: applies the current step's selection code to the match
// pulses, with Final-bound matches first and then the lowest channel.
// Assumes arm overrides every match in the same cycle.
module dbgseq_fsm
    import dbgseq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            arm,
    input  logic [NUM_CH-1:0]               match,
    input  logic [NUM_STEPS-1:0][SEL_W-1:0] sel_codes,
    output seq_state_t                      state,
    output logic                            active,
    output logic                            trig
);

    seq_state_t        nxt;
    logic              go_final;
    logic [SEL_W-1:0]  cur_code;
    sel_rule_t         rule;
    logic [NUM_CH-1:0] fin_hit;
    logic [NUM_CH-1:0] step_hit;

    assign active = (state == ST_S1) || (state == ST_S2) || (state == ST_S3);

    // Selects the code that belongs to the current step.
    always_comb begin
        case (state)
            ST_S1:   cur_code = sel_codes[0];
            ST_S2:   cur_code = sel_codes[1];
            ST_S3:   cur_code = sel_codes[2];
            default: cur_code = '0;
        endcase
    end

    assign rule     = decode_sel(cur_code);
    assign fin_hit  = rule.to_final & match;
    assign step_hit = rule.to_step & match;

    // Next-state choice: Final first, then the lowest-numbered step match.
    always_comb begin
        nxt      = state;
        go_final = 1'b0;
        if (active) begin
            if (|fin_hit) begin
                nxt      = ST_FINAL;
                go_final = 1'b1;
            end else begin
                for (int i = NUM_CH - 1; i >= 0; i--) begin
                    if (step_hit[i]) nxt = seq_state_t'({1'b0, rule.step_dest[i]});
                end
            end
        end
    end

    // State and trigger registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            trig  <= 1'b0;
        end else if (arm) begin
            state <= ST_S1;
            trig  <= 1'b0;
        end else begin
            state <= nxt;
            trig  <= go_final;
        end
    end

endmodule

// File: rtl/dbgseq_flags.sv
// Sticky match flags: one bit per channel, set by a match while armed and
// cleared only by arming. Assumes that no software path reaches these bits.
module dbgseq_flags
    import dbgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              active,
    input  logic [NUM_CH-1:0] match,
    output logic [NUM_CH-1:0] flags
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        // Per-channel sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                   flags[c] <= 1'b0;
            else if (arm)                 flags[c] <= 1'b0;
            else if (active && match[c])  flags[c] <= 1'b1;
        end
    end

endmodule

// File: rtl/dbgseq_top.sv
// Top level of the debug trigger sequencer: joins the register file, the
// state sequencer and the sticky flags. Assumes synchronous match pulses.
module dbgseq_top
    import dbgseq_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 6'h26,
    parameter logic [ADDR_W-1:0] WIN_OFS  = 6'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [3:0]        match_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [2:0]        state_o,
    output logic              trig_o,
    output logic [3:0]        flags_o
);

    logic [NUM_STEPS-1:0][SEL_W-1:0] sel_codes;
    logic                            arm_wr;
    logic                            arm;
    logic                            active;
    seq_state_t                      state;

    assign arm     = arm_i | arm_wr;
    assign state_o = state;

    dbgseq_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .WIN_OFS (WIN_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .flags    (flags_o),
        .sel_codes(sel_codes),
        .arm_wr   (arm_wr),
        .reg_rdata(reg_rdata)
    );

    dbgseq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .match    (match_i),
        .sel_codes(sel_codes),
        .state    (state),
        .active   (active),
        .trig     (trig_o)
    );

    dbgseq_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .active(active),
        .match (match_i),
        .flags (flags_o)
    );

endmodule

// File: rtl/dbgseq_checker.sv
// Checker: temporal properties of the sequencer observed at the top-level ports.
// Assumes the control offset and arm bit used by the top.
module dbgseq_checker #(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 6'h26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_i,
    input logic [3:0]        match_i,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [2:0]        state_o,
    input logic              trig_o,
    input logic [3:0]        flags_o
);

    logic arm_seen;
    logic disarmed;

    assign arm_seen = arm_i || (reg_wr && (reg_addr == CTRL_OFS) && reg_wdata[7]);
    assign disarmed = (state_o == 3'd0) || (state_o == 3'd4);

    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    a_r2_arm_to_step1: assert property (@(posedge clk) disable iff (!rst_n)
        arm_seen |=> (state_o == 3'd1) && (flags_o == 4'b0));

    a_r3_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(match_i)) == 4'b0));

    a_r4_flag_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_seen |=> (($past(flags_o) & ~flags_o) == 4'b0));

    a_r5_disarmed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_seen && disarmed) |=> ($stable(state_o) && $stable(flags_o)));

    a_r9_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    a_r9_trig_in_final: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (state_o == 3'd4));

    a_r9_final_entry_trig: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4) && ($past(state_o) != 3'd4)) |-> trig_o);

endmodule

bind dbgseq_top dbgseq_checker #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .match_i  (match_i),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .state_o  (state_o),
    .trig_o   (trig_o),
    .flags_o  (flags_o)
);

// File: tb/dbgseq_top_test.sv
`timescale 1ns/1ps
module dbgseq_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0;
    logic [3:0] match_i = '0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] state_o;
    logic       trig_o;
    logic [3:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model of the block.
    logic [2:0] m_state = 3'd0;
    logic       m_trig  = 1'b0;
    logic [3:0] m_flags = '0;
    logic [1:0] m_bank  = '0;
    logic [3:0] m_code [3];

    always #2 clk = ~clk;

    dbgseq_top uut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .match_i(match_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .state_o(state_o), .trig_o(trig_o), .flags_o(flags_o)
    );

    // Destination of channel ch under a code: 0 none, 1..3 step, 4 Final.
    function automatic logic [2:0] tb_dest(input logic [3:0] code, input int ch);
        case (code)
            4'h1: return 3'd4;
            4'h2, 4'h3, 4'h4, 4'h5: return (ch == int'(code) - 2) ? 3'd4 : 3'd0;
            4'h6: return (ch == 0) ? 3'd1 : 3'd0;
            4'h7: return (ch == 1) ? 3'd2 : 3'd0;
            4'h8: return (ch == 2) ? 3'd3 : 3'd0;
            4'h9: return (ch == 3) ? 3'd2 : 3'd0;
            4'hA: return (ch == 0) ? 3'd4 : (ch == 1) ? 3'd2 : 3'd0;
            4'hB: return (ch == 1) ? 3'd4 : (ch == 2) ? 3'd3 : 3'd0;
            4'hC: return (ch == 2) ? 3'd4 : (ch == 3) ? 3'd1 : 3'd0;
            4'hD: return (ch == 3) ? 3'd4 : (ch == 0) ? 3'd2 : 3'd0;
            4'hE: return (ch == 1) ? 3'd2 : (ch == 3) ? 3'd3 : 3'd0;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [7:0] tb_read(input logic [5:0] a);
        if (a == 6'h26) return {6'b0, m_bank};
        if (a == 6'h27) return (m_bank == 2'd3) ? {4'b0, m_flags} : {4'b0, m_code[m_bank]};
        return 8'h00;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Model update for one clock edge with the present inputs.
    task automatic model_edge();
        logic       arm_now;
        logic [2:0] nx;
        logic       fin;
        arm_now = arm_i || (reg_wr && reg_addr == 6'h26 && reg_wdata[7]);
        nx = m_state;
        fin = 1'b0;
        if (m_state >= 3'd1 && m_state <= 3'd3) begin
            for (int c = 0; c < 4; c++)
                if (match_i[c] && tb_dest(m_code[m_state - 1], c) == 3'd4) fin = 1'b1;
            if (fin) nx = 3'd4;
            else
                for (int c = 3; c >= 0; c--)
                    if (match_i[c] && tb_dest(m_code[m_state - 1], c) != 3'd0)
                        nx = tb_dest(m_code[m_state - 1], c);
        end
        if (reg_wr && reg_addr == 6'h27 && m_bank != 2'd3) m_code[m_bank] = reg_wdata[3:0];
        if (arm_now) begin
            m_state = 3'd1; m_flags = '0; m_trig = 1'b0;
        end else if (m_state >= 3'd1 && m_state <= 3'd3) begin
            m_flags = m_flags | match_i;
            m_trig  = fin;
            m_state = nx;
        end else begin
            m_trig = 1'b0;
        end
        if (reg_wr && reg_addr == 6'h26) m_bank = reg_wdata[1:0];
    endtask

    // One cycle: drive at negedge, check read data, take the edge, check outputs.
    task automatic step(input string tag, input logic arm, input logic [3:0] m,
                        input logic wr, input logic [5:0] a, input logic [7:0] d);
        arm_i = arm; match_i = m; reg_wr = wr; reg_addr = a; reg_wdata = d;
        #1;
        check(tag, "rdata", int'(reg_rdata), int'(tb_read(a)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "state", int'(state_o), int'(m_state));
        check(tag, "flags", int'(flags_o), int'(m_flags));
        check(tag, "trig", int'(trig_o), int'(m_trig));
    endtask

    task automatic wreg(input string tag, input logic [5:0] a, input logic [7:0] d);
        step(tag, 1'b0, 4'b0, 1'b1, a, d);
    endtask

    task automatic idle(input string tag, input logic [3:0] m);
        step(tag, 1'b0, m, 1'b0, 6'h27, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_code[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1", "state", int'(state_o), 0);
        check("R1", "flags", int'(flags_o), 0);
        check("R1", "trig", int'(trig_o), 0);
        step("R1", 1'b0, 4'b0, 1'b0, 6'h26, 8'h00);
        // R10: program and read back codes via banks
        wreg("R10", 6'h26, 8'h00); wreg("R10", 6'h27, 8'h0E);
        wreg("R10", 6'h26, 8'h01); wreg("R10", 6'h27, 8'h00);
        wreg("R10", 6'h26, 8'h02); wreg("R10", 6'h27, 8'h0A);
        for (int b = 0; b < 4; b++) begin
            wreg("R10", 6'h26, 8'(b));
            step("R10", 1'b0, 4'b0, 1'b0, 6'h27, 8'h00);
        end
        step("R10", 1'b0, 4'b0, 1'b0, 6'h15, 8'h00);
        // R5: matches while idle ignored
        idle("R5", 4'hF);
        // R2: arm by strobe
        step("R2", 1'b1, 4'b0, 1'b0, 6'h27, 8'h00);
        // R8 + R3: M1->S2 and M3->S3 together, lower channel wins
        idle("R8", 4'b1010);
        // R7: reserved code in Step2, nothing moves, flags still gather
        idle("R7", 4'hF);
        // R4: write to flag window (bank 3) ignored
        wreg("R4", 6'h27, 8'h00);
        idle("R4", 4'b0);
        // R2: arm by control write with a simultaneous match
        step("R2", 1'b0, 4'b0001, 1'b1, 6'h26, 8'h83);
        idle("R3", 4'b1000);
        // R8 + R9: in Step3 code A, M0 to Final beats M1 to Step2
        idle("R8", 4'b0011);
        idle("R9", 4'b0000);
        idle("R5", 4'b1111);
        idle("R4", 4'b0000);
        // R6: any-match code in Step1
        wreg("R6", 6'h26, 8'h00); wreg("R6", 6'h27, 8'h01);
        step("R6", 1'b1, 4'b0, 1'b0, 6'h27, 8'h00);
        idle("R6", 4'b0100);
        idle("R9", 4'b0000);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic       ra;
            logic [3:0] rm;
            logic       rw;
            logic [5:0] rad;
            logic [7:0] rd;
            int         sel;
            ra = ($urandom % 40) == 0;
            for (int c = 0; c < 4; c++) rm[c] = ($urandom % 4) == 0;
            rw = ($urandom % 6) == 0;
            sel = $urandom % 8;
            rad = (sel < 3) ? 6'h26 : (sel < 7) ? 6'h27 : 6'($urandom);
            rd = 8'($urandom);
            if (rad == 6'h26 && ($urandom % 4) != 0) rd[7] = 1'b0;
            step("R6", ra, rm, rw, rad, rd);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule